// File: doc/BRIEF.md
# Dual-Channel Serial Converter Command Decoder

This block is the digital side of a two-channel converter programmed over a three-wire serial link. It samples chip select, serial clock and serial data in a fast system clock. It assembles 16-bit command words and, when chip select rises, executes the word. Each channel holds a 13-bit input (staging) register and a 13-bit output register. The output registers drive the converter codes. Commands can stage a value, move staged values to the outputs for one or both channels, load both channels at once, shut channels down, drive a general-purpose logic output, or pick the edge on which the serial output moves.

The serial output is the far end of the 16-bit shift register, so several devices can be chained data-out to data-in under one chip select. A shutdown-permit input blocks software shutdown while it is low. When it falls, any channel in shutdown wakes at once with its code intact. An active-low clear input zeroes every code register.

Top module: `dac_cmd_core`

## Requirements
- R1: A frame is sent MSB first; the word executed is the last 16 bits shifted in before chip select rises, split as bits 15:13 = header (A0,C1,C0), bits 12:0 = data; earlier bits of a longer frame are ignored.
- R2: Bits are taken only on serial clock rising edges while chip select is low; clock edges with chip select high shift nothing, and nothing executes until chip select rises.
- R3: Header 001 stages data into channel A's input register and header 101 into channel B's; neither output register changes.
- R4: Header 010 stages data into A and then copies both input registers to the outputs; header 110 does the same with B staged.
- R5: Header 011 writes the data into both input and both output registers.
- R6: Header 100 copies both input registers to the outputs; with header 000, extended code (bits 12:9) 0001 copies A only and 0101 copies B only.
- R7: Header 111 shuts down both channels, extended 0110 channel A and 0111 channel B; codes are kept in shutdown.
- R8: While sd_permit is low, shutdown commands are ignored; a fall of sd_permit clears both shutdown flags immediately, keeping the codes.
- R9: Any command that writes a channel's output register clears its shutdown flag; staging into the input register alone does not.
- R10: Extended 0011 drives gpo high, 0010 drives it low.
- R11: Extended 0100 selects the serial output edge from bit 8 (0 falling, 1 rising). In falling mode a bit appears on sdo at the falling edge 16 clocks after it entered; in rising mode it appears at the rising edge, half a clock earlier.
- R12: Reset zeroes all code registers and shutdown flags, drives gpo low and selects falling-edge mode; clr_n low zeroes all input and output registers.
- R13: Extended codes 0000 and 1xxx change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| clr_n | input | 1 | Active-low clear of all code registers |
| sd_permit | input | 1 | Shutdown permit; low blocks and cancels shutdown |
| code_a | output | 13 | Channel A output register |
| code_b | output | 13 | Channel B output register |
| shdn_a | output | 1 | Channel A shut down |
| shdn_b | output | 1 | Channel B shut down |
| gpo | output | 1 | Programmable logic output |
| sdo | output | 1 | Serial data out for chaining |

## Verification
The assertions assume the serial pins change slowly compared with the system clock. They also assume a serial clock edge and a chip select rise never land in the same synchronized cycle, so a word is complete before it executes. The bench holds each serial clock phase for eight system clocks and leaves several clocks of settling around every chip select change. It changes sd_permit and clr_n only between frames. Random commands are drawn over every header and extended code with sd_permit held high. Lockout and clear are covered by directed steps.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int HDR_W = 3;
  localparam int EXT_W = 4;

  typedef enum logic [3:0] {
    OP_NOP, OP_STG_A, OP_STG_B, OP_STG_A_UPD, OP_STG_B_UPD, OP_LD_BOTH,
    OP_UPD_BOTH, OP_SD_BOTH, OP_UPD_A, OP_UPD_B, OP_GPO_LO, OP_GPO_HI,
    OP_SD_A, OP_SD_B, OP_EDGE_SEL
  } op_e;

  function automatic op_e decode_op(input logic [HDR_W-1:0] hdr,
                                    input logic [EXT_W-1:0] ext);
    op_e r;
    case (hdr)
      3'b001: r = OP_STG_A;
      3'b101: r = OP_STG_B;
      3'b010: r = OP_STG_A_UPD;
      3'b110: r = OP_STG_B_UPD;
      3'b011: r = OP_LD_BOTH;
      3'b100: r = OP_UPD_BOTH;
      3'b111: r = OP_SD_BOTH;
      default: begin
        case (ext)
          4'b0001: r = OP_UPD_A;
          4'b0101: r = OP_UPD_B;
          4'b0010: r = OP_GPO_LO;
          4'b0011: r = OP_GPO_HI;
          4'b0110: r = OP_SD_A;
          4'b0111: r = OP_SD_B;
          4'b0100: r = OP_EDGE_SEL;
          default: r = OP_NOP;
        endcase
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dcc_sync.sv
module dcc_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= RESET_VAL;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= RESET_VAL;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcc_shifter.sv
module dcc_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              rise_mode,
  output logic [WORD_W-1:0] word,
  output logic              cmd_go,
  output logic              sdo
);
  logic              sclk_q, cs_q, sdo_q;
  logic [WORD_W-1:0] sr;
  logic              sclk_rise, sclk_fall;

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign cmd_go    = cs_n_s & ~cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      sr     <= '0;
      sdo_q  <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_n_s;
      if (!cs_n_s && sclk_rise) sr <= {sr[WORD_W-2:0], sdi_s};
      if (!cs_n_s) begin
        if (rise_mode && sclk_rise)       sdo_q <= sr[WORD_W-2];
        else if (!rise_mode && sclk_fall) sdo_q <= sr[WORD_W-1];
      end
    end
  end

  assign word = sr;
  assign sdo  = sdo_q;

  AST_SR_FROZEN_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |=> $stable(sr)); // R2
  AST_SDO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_mode && !sclk_fall) |=> $stable(sdo_q)); // R11
endmodule

// File: rtl/dcc_decode.sv
module dcc_decode
  import dcc_pkg::*;
#(
  parameter int DATA_W = 13,
  parameter int WORD_W = DATA_W + HDR_W,
  parameter int NCH = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_s,
  input  logic                         lock_s,
  input  logic                         lock_raw,
  input  logic                         cmd_go,
  input  logic [WORD_W-1:0]            cmd_word,
  output logic [NCH-1:0][DATA_W-1:0]   codes,
  output logic [NCH-1:0]               shdn,
  output logic                         gpo,
  output logic                         rise_mode
);
  localparam int EXT_LSB = DATA_W - EXT_W;

  op_e               op;
  logic [DATA_W-1:0] data;
  logic [NCH-1:0]    ld_in, ld_out_data, ld_out_in, sd_set;
  logic              gpo_q, mode_q;

  assign data = cmd_word[DATA_W-1:0];
  assign op   = decode_op(cmd_word[WORD_W-1 -: HDR_W], cmd_word[DATA_W-1 -: EXT_W]);

  always_comb begin
    ld_in = '0; ld_out_data = '0; ld_out_in = '0; sd_set = '0;
    if (cmd_go) begin
      case (op)
        OP_STG_A:     ld_in[0] = 1'b1;
        OP_STG_B:     ld_in[1] = 1'b1;
        OP_STG_A_UPD: begin ld_in[0] = 1'b1; ld_out_data[0] = 1'b1; ld_out_in[1] = 1'b1; end
        OP_STG_B_UPD: begin ld_in[1] = 1'b1; ld_out_data[1] = 1'b1; ld_out_in[0] = 1'b1; end
        OP_LD_BOTH:   begin ld_in = '1; ld_out_data = '1; end
        OP_UPD_BOTH:  ld_out_in = '1;
        OP_UPD_A:     ld_out_in[0] = 1'b1;
        OP_UPD_B:     ld_out_in[1] = 1'b1;
        OP_SD_BOTH:   sd_set = '1;
        OP_SD_A:      sd_set[0] = 1'b1;
        OP_SD_B:      sd_set[1] = 1'b1;
        default: ;
      endcase
    end
  end

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_ch
      logic [DATA_W-1:0] in_r, out_r;
      logic              sd_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          in_r  <= '0;
          out_r <= '0;
          sd_q  <= 1'b0;
        end else begin
          if (clr_s) begin
            in_r  <= '0;
            out_r <= '0;
          end else begin
            if (ld_in[ch]) in_r <= data;
            if (ld_out_data[ch])    out_r <= data;
            else if (ld_out_in[ch]) out_r <= in_r;
          end
          if (!lock_s)                                sd_q <= 1'b0;
          else if (sd_set[ch])                        sd_q <= 1'b1;
          else if (ld_out_data[ch] || ld_out_in[ch])  sd_q <= 1'b0;
        end
      end
      assign codes[ch] = out_r;
      assign shdn[ch]  = sd_q & lock_raw;

      AST_SD_NEEDS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_q) |-> $past(lock_s)); // R8
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpo_q  <= 1'b0;
      mode_q <= 1'b0;
    end else if (cmd_go) begin
      if (op == OP_GPO_LO)   gpo_q  <= 1'b0;
      if (op == OP_GPO_HI)   gpo_q  <= 1'b1;
      if (op == OP_EDGE_SEL) mode_q <= cmd_word[EXT_LSB-1];
    end
  end

  assign gpo       = gpo_q;
  assign rise_mode = mode_q;

  AST_STAGE_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !clr_s && (op == OP_STG_A || op == OP_STG_B)) |=> $stable(codes)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (codes[0] == '0 && codes[1] == '0)); // R12
  AST_UPDATE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && op == OP_UPD_BOTH) |=> (shdn == '0)); // R9
  AST_GPO_ON_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_go |=> $stable(gpo_q) && $stable(mode_q)); // R10
endmodule

// File: rtl/dac_cmd_core.sv
module dac_cmd_core #(
  parameter int DATA_W = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              clr_n,
  input  logic              sd_permit,
  output logic [DATA_W-1:0] code_a,
  output logic [DATA_W-1:0] code_b,
  output logic              shdn_a,
  output logic              shdn_b,
  output logic              gpo,
  output logic              sdo
);
  localparam int WORD_W = DATA_W + dcc_pkg::HDR_W;
  localparam int NCH = 2;
  localparam int NSYNC = 5;

  logic [NSYNC-1:0] raw_in, syn;
  logic             cs_n_s, sclk_s, sdi_s, lock_s, clr_s;
  logic [WORD_W-1:0] word;
  logic             cmd_go, rise_mode;
  logic [NCH-1:0][DATA_W-1:0] codes;
  logic [NCH-1:0]   shdn;

  assign raw_in = {clr_n, sd_permit, sdi, sclk, cs_n};

  dcc_sync #(.WIDTH(NSYNC), .STAGES(SYNC_STAGES), .RESET_VAL(5'b10001)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(syn));

  assign cs_n_s = syn[0];
  assign sclk_s = syn[1];
  assign sdi_s  = syn[2];
  assign lock_s = syn[3];
  assign clr_s  = ~syn[4];

  dcc_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .rise_mode(rise_mode), .word(word), .cmd_go(cmd_go), .sdo(sdo));

  dcc_decode #(.DATA_W(DATA_W), .WORD_W(WORD_W), .NCH(NCH)) u_dec (
    .clk(clk), .rst_n(rst_n), .clr_s(clr_s), .lock_s(lock_s), .lock_raw(sd_permit),
    .cmd_go(cmd_go), .cmd_word(word), .codes(codes), .shdn(shdn),
    .gpo(gpo), .rise_mode(rise_mode));

  assign code_a = codes[0];
  assign code_b = codes[1];
  assign shdn_a = shdn[0];
  assign shdn_b = shdn[1];
endmodule

// File: tb/tb_dac_cmd_core.sv
module tb_dac_cmd_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, clr_n = 1'b1, sd_permit = 1'b1;
  logic [12:0] code_a, code_b;
  logic shdn_a, shdn_b, gpo, sdo;

  dac_cmd_core dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .clr_n(clr_n), .sd_permit(sd_permit), .code_a(code_a), .code_b(code_b),
    .shdn_a(shdn_a), .shdn_b(shdn_b), .gpo(gpo), .sdo(sdo));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;
  logic [12:0] m_in [2];
  logic [12:0] m_out [2];
  logic m_sd [2];
  logic m_gpo = 1'b0, m_mode = 1'b0;
  logic [31:0] cap;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " code_a"}, 32'(code_a), 32'(m_out[0]));
    chk({req, " code_b"}, 32'(code_b), 32'(m_out[1]));
    chk({req, " shdn_a"}, 32'(shdn_a), 32'(m_sd[0] & sd_permit));
    chk({req, " shdn_b"}, 32'(shdn_b), 32'(m_sd[1] & sd_permit));
    chk({req, " gpo"},    32'(gpo),    32'(m_gpo));
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // reference model of one executed command word
  task automatic model(input logic [15:0] w);
    logic [12:0] d;
    d = w[12:0];
    unique case (w[15:13])
      3'd1: m_in[0] = d;
      3'd5: m_in[1] = d;
      3'd2, 3'd6: begin
        m_in[w[15] ? 1 : 0] = d;
        m_out[0] = m_in[0]; m_out[1] = m_in[1];
        m_sd[0] = 1'b0; m_sd[1] = 1'b0;
      end
      3'd3: begin m_in[0] = d; m_in[1] = d; m_out[0] = d; m_out[1] = d;
        m_sd[0] = 1'b0; m_sd[1] = 1'b0; end
      3'd4: begin m_out[0] = m_in[0]; m_out[1] = m_in[1];
        m_sd[0] = 1'b0; m_sd[1] = 1'b0; end
      3'd7: if (sd_permit) begin m_sd[0] = 1'b1; m_sd[1] = 1'b1; end
      default: begin
        case (w[12:9])
          4'd1: begin m_out[0] = m_in[0]; m_sd[0] = 1'b0; end
          4'd5: begin m_out[1] = m_in[1]; m_sd[1] = 1'b0; end
          4'd2: m_gpo = 1'b0;
          4'd3: m_gpo = 1'b1;
          4'd6: if (sd_permit) m_sd[0] = 1'b1;
          4'd7: if (sd_permit) m_sd[1] = 1'b1;
          4'd4: m_mode = w[8];
          default: ;
        endcase
      end
    endcase
  endtask

  task automatic shift_bit(input logic b, input int j);
    sdi = b; clks(8);
    sclk = 1'b1; clks(8);
    if (j < 32) cap[j] = sdo;
    sclk = 1'b0;
  endtask

  task automatic send(input logic [31:0] w, input int nbits, input logic do_model);
    cs_n = 1'b0; clks(4);
    for (int j = 0; j < nbits; j++) shift_bit(w[nbits-1-j], j);
    clks(4);
    cs_n = 1'b1; clks(12);
    if (do_model) model(w[15:0]);
  endtask

  initial begin
    logic [15:0] w1, exp_v, got_v;
    m_in[0] = '0; m_in[1] = '0; m_out[0] = '0; m_out[1] = '0;
    m_sd[0] = 1'b0; m_sd[1] = 1'b0;
    clks(5); rst_n = 1'b1; clks(5);
    chk_all("R12 reset");
    chk("R12 reset sdo", 32'(sdo), 32'd0);

    // R1: 24-bit frame, only the trailing 16 bits act (load both = 011)
    send({8'hE5, 16'h6ABC}, 24, 1'b1);
    chk_all("R1 R5 long frame load both");
    chk("R5 code_a", 32'(code_a), 32'h0ABC);

    // R2: nothing happens before chip select rises
    cs_n = 1'b0; clks(4);
    for (int j = 0; j < 16; j++) shift_bit(logic'(16'h6555 >> (15 - j)), 40);
    clks(10);
    chk("R2 before cs rise", 32'(code_a), 32'h0ABC);
    cs_n = 1'b1; clks(12); model(16'h6555);
    chk_all("R2 after cs rise");
    // R2: clocks with cs high shift nothing
    send(32'h0000, 16, 1'b1);
    for (int j = 0; j < 16; j++) shift_bit(1'b1, 40);
    send(32'h0, 0, 1'b0); model(16'h0000);
    chk_all("R2 cs high clocks ignored");

    // R3 staging only, then R6 update both
    send(32'h2111, 16, 1'b1);
    send(32'hA222, 16, 1'b1);
    chk_all("R3 stage only");
    chk("R3 code_a held", 32'(code_a), 32'h0555);
    send(32'h8000, 16, 1'b1);
    chk_all("R6 update both");
    chk("R6 code_b", 32'(code_b), 32'h0222);
    // R4
    send(32'h4333, 16, 1'b1);
    chk_all("R4 stage A and update");
    send(32'hC444, 16, 1'b1);
    chk_all("R4 stage B and update");
    chk("R4 code_a", 32'(code_a), 32'h0333);
    // R6 single channel copies
    send(32'h2010, 16, 1'b1);
    send(32'h0200, 16, 1'b1);
    chk_all("R6 copy A only");
    send(32'hA020, 16, 1'b1);
    send(32'h0A00, 16, 1'b1);
    chk_all("R6 copy B only");
    chk("R6 code_b", 32'(code_b), 32'h0020);
    // R10
    send(32'h0600, 16, 1'b1);
    chk("R10 gpo high", 32'(gpo), 32'd1);
    send(32'h0400, 16, 1'b1);
    chk("R10 gpo low", 32'(gpo), 32'd0);
    // R7, R9
    send(32'h0C00, 16, 1'b1);
    chk_all("R7 shut A");
    chk("R7 shdn_a", 32'(shdn_a), 32'd1);
    send(32'h0E00, 16, 1'b1);
    chk_all("R7 shut B, codes kept");
    send(32'h2777, 16, 1'b1);
    chk("R9 stage does not wake", 32'(shdn_a), 32'd1);
    send(32'h0200, 16, 1'b1);
    chk_all("R9 copy wakes A");
    chk("R9 shdn_b still", 32'(shdn_b), 32'd1);
    // R8 lockout
    sd_permit = 1'b0; #1;
    chk("R8 async wake", 32'(shdn_b), 32'd0);
    clks(6); m_sd[0] = 1'b0; m_sd[1] = 1'b0;
    chk_all("R8 codes kept after wake");
    send(32'hE000, 16, 1'b1);
    chk_all("R8 shutdown blocked");
    sd_permit = 1'b1; clks(6);
    chk_all("R8 permit back, still awake");
    send(32'hE000, 16, 1'b1);
    chk_all("R7 shut both");
    send(32'h8000, 16, 1'b1);
    chk_all("R9 update both wakes");
    // R13
    send(32'h1E00, 16, 1'b1);
    send(32'h1000, 16, 1'b1);
    send(32'h0000, 16, 1'b1);
    chk_all("R13 no-op codes");

    // R11 serial out, falling mode then rising mode
    w1 = 16'hB35A;
    send({w1, 16'h0000}, 32, 1'b1);
    exp_v = '0; got_v = '0;
    for (int j = 0; j < 15; j++) begin exp_v[j] = w1[15-j]; got_v[j] = cap[16+j]; end
    chk("R11 falling-edge lag", 32'(got_v), 32'(exp_v));
    send(32'h0900, 16, 1'b1);
    send({w1, 16'h0000}, 32, 1'b1);
    for (int j = 0; j < 15; j++) begin exp_v[j] = w1[14-j]; got_v[j] = cap[16+j]; end
    chk("R11 rising-edge lag", 32'(got_v), 32'(exp_v));
    send(32'h0800, 16, 1'b1);

    // R12 clear
    clr_n = 1'b0; clks(4); clr_n = 1'b1; clks(10);
    m_in[0] = '0; m_in[1] = '0; m_out[0] = '0; m_out[1] = '0;
    chk_all("R12 clear");
    send(32'h8000, 16, 1'b1);
    chk_all("R12 inputs cleared too");

    // random commands
    void'($urandom(32'd7717));
    for (int k = 0; k < 80; k++) begin
      logic [15:0] w;
      w = 16'($urandom);
      send({16'h0, w}, 16, 1'b1);
      chk_all("R1 R3 R4 R5 R6 R7 R9 R10 R13 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule